// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between up to eight device interrupt request lines and a processor with a single interrupt input. Each request is sampled every clock, gated by a software-written enable register, and arbitrated under a fixed priority in which line 0 ranks highest and line 7 lowest. When the best enabled request may be served, the block raises `int_o`. The processor answers with a one-cycle acknowledge pulse. The block then returns an 8-bit type number and the matching handler-table byte address, which is the type number times four.

An in-service record tracks the handlers the processor is running. A request that outranks every in-service level interrupts the running handler. A request of equal or lower rank waits until the handlers above it finish. Software ends a handler by writing an end-of-interrupt command. That command retires the highest-ranked in-service level, after which the best waiting request that outranks the resumed level is signalled.

Registers are written over a small synchronous write-only bus with a 2-bit address. Address 0 holds the line enables, address 1 holds the 5-bit vector base, and address 2 is the end-of-interrupt command.

Top module: `nested_irq_ctrl`

## Requirements
- R1: Request lines are level-sensitive and are registered once per clock. With its line enabled and nothing in service, a request that is high before a clock edge makes `int_o` high right after that edge.
- R2: Bus address 0 is the enable register, where bit i set to 1 enables line i. Its reset value is 0x00. A line whose enable bit is 0 never causes `int_o`, is never chosen on acknowledge, and a write takes effect from the next clock.
- R3: Priority is fixed, with line 0 highest and line 7 lowest. On acknowledge, the highest-priority enabled pending line is the one served.
- R4: An `ack_i` pulse while `int_o` is high is accepted. In the next cycle `vec_valid_o` is high for exactly one cycle with `vec_o` = {base, line index[2:0]}, and that line enters service.
- R5: An `ack_i` while `int_o` is low is ignored. `vec_valid_o` stays low, `vec_o` keeps its value and the in-service state does not change.
- R6: Bus address 1 bits [4:0] form the vector base, which resets to 0. `vec_o` holds the last delivered vector until the next accepted acknowledge. `tbl_addr_o` always equals `vec_o` multiplied by 4.
- R7: A pending enabled request whose priority is strictly higher than the highest-priority in-service line raises `int_o`, so it pre-empts the running handler.
- R8: A request whose priority is equal to or lower than the highest-priority in-service line keeps `int_o` low while that line is in service. This includes a line that is still requesting while it is in service.
- R9: A bus write to address 2, with any data, removes the highest-priority line from service. After that, the best pending request that outranks the remaining in-service lines is signalled on `int_o`.
- R10: After reset, `int_o`, `vec_valid_o`, `vec_o` and `tbl_addr_o` are all 0 and no line is in service.
- R11: Bus writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 8 | Level-sensitive device requests, line 0 highest priority |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 enable, 1 base, 2 end-of-interrupt, 3 unused |
| bus_wdata_i | input | 8 | Register write data |
| int_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Processor acknowledge, one-cycle pulse |
| vec_valid_o | output | 1 | One-cycle strobe for a delivered vector |
| vec_o | output | 8 | Interrupt type number {base, line index} |
| tbl_addr_o | output | 10 | Handler table byte address, vec_o times 4 |

## Verification
Single isolated requests on different lines check vector formation and the one-cycle request latency. Simultaneous requests on several lines separate true priority from order of arrival. A three-level nesting sequence runs a low line, then a pre-empting high line, then a middle line that must wait. This sequence tells strict pre-emption apart from deferral and checks which level is served after each end-of-interrupt. A long pseudo-random mix of requests, enable and base writes, stray acknowledges and end-of-interrupt writes is compared every cycle against a stack-based reference model. It exposes disagreements in corner cases such as an acknowledge and an end-of-interrupt in the same cycle.

// File: rtl/npic_pkg.sv
package npic_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_BASE   = 2'd1,
    REG_EOI    = 2'd2,
    REG_RSVD   = 2'd3
  } npic_reg_e;
endpackage

// File: rtl/npic_prio_pick.sv
// Lowest set index wins (index 0 = highest priority).
module npic_prio_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = i[IW-1:0];
    end
    oh_o = vec_i & ~(vec_i - 1'b1);
  end
endmodule

// File: rtl/npic_regs.sv
module npic_regs
  import npic_pkg::*;
#(
  parameter int N      = 8,
  parameter int DW     = 8,
  parameter int BASE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N-1:0]      en_o,
  output logic [BASE_W-1:0] base_o,
  output logic              eoi_o
);
  npic_reg_e sel;
  assign sel   = npic_reg_e'(addr_i);
  assign eoi_o = we_i && (sel == REG_EOI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      base_o <= '0;
    end else if (we_i) begin
      case (sel)
        REG_ENABLE: en_o   <= wdata_i[N-1:0];
        REG_BASE:   base_o <= wdata_i[BASE_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/npic_isr.sv
module npic_isr #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_oh_i,
  input  logic         eoi_i,
  output logic [N-1:0] isr_o
);
  logic [N-1:0] top_oh;
  logic [N:0]   at_or_above;

  assign top_oh      = isr_o & ~(isr_o - 1'b1);
  assign at_or_above = ({1'b0, set_oh_i} << 1) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= (isr_o & ~(eoi_i ? top_oh : '0)) | set_oh_i;
  end

  AST_SET_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_oh_i)); // R4
  AST_NEST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_oh_i) |-> ((isr_o & at_or_above[N-1:0]) == '0)); // R7
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && (|isr_o) && (set_oh_i == '0)) |=>
      ($countones(isr_o) == $past($countones(isr_o)) - 1)); // R9
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int N     = 8,
  parameter int VEC_W = 8,
  localparam int IW     = (N > 1) ? $clog2(N) : 1,
  localparam int BASE_W = VEC_W - IW,
  localparam int AW     = VEC_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     irq_req_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [VEC_W-1:0] bus_wdata_i,
  output logic             int_o,
  input  logic             ack_i,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [AW-1:0]    tbl_addr_o
);
  logic [N-1:0]      req_q, en_q, isr_q, pend, pend_oh, isr_oh, set_oh;
  logic [BASE_W-1:0] base_q;
  logic              eoi, pend_any, isr_any, take;
  logic [IW-1:0]     pend_idx, isr_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= irq_req_i;
  end

  npic_regs #(.N(N), .DW(VEC_W), .BASE_W(BASE_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .en_o(en_q), .base_o(base_q), .eoi_o(eoi)
  );

  assign pend = req_q & en_q & ~isr_q;

  npic_prio_pick #(.N(N)) i_pick_pend (
    .vec_i(pend), .any_o(pend_any), .idx_o(pend_idx), .oh_o(pend_oh)
  );
  npic_prio_pick #(.N(N)) i_pick_isr (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_idx), .oh_o(isr_oh)
  );

  // Signal only when the best pending line outranks the top in-service line.
  assign int_o  = pend_any && (!isr_any || (pend_idx < isr_idx));
  assign take   = ack_i && int_o;
  assign set_oh = take ? pend_oh : '0;

  npic_isr #(.N(N)) i_isr (
    .clk_i, .rst_ni, .set_oh_i(set_oh), .eoi_i(eoi), .isr_o(isr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      vec_valid_o <= take;
      if (take) vec_o <= {base_q, pend_idx};
    end
  end

  assign tbl_addr_o = {vec_o, 2'b00};

  AST_ACK_GIVES_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> vec_valid_o); // R4
  AST_STRAY_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> (!vec_valid_o && $stable(vec_o))); // R5
  AST_VEC_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (vec_o[VEC_W-1:IW] == $past(base_q))); // R6
  AST_SERVED_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> ((set_oh & en_q) == set_oh)); // R2
  AST_ISR_ONEHOT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_oh)); // R9
endmodule

// File: tb/test_nested_irq_ctrl.sv
module test_nested_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ack = 1'b0;
  logic       int_w, vld_w;
  logic [7:0] vec_w;
  logic [9:0] tbl_w;

  always #2 clk = ~clk;

  nested_irq_ctrl i_nested_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .int_o(int_w), .ack_i(ack),
    .vec_valid_o(vld_w), .vec_o(vec_w), .tbl_addr_o(tbl_w)
  );

  // Reference model: nesting kept as a stack of line numbers, top = front.
  bit   m_req[8];
  bit   m_en[8];
  int   m_base;
  int   stk[$];
  bit   m_vld;
  int   m_vec;
  int   n_cmp = 0, n_bad = 0, cycles = 0;
  string cur = "R10";

  function automatic bit in_svc(int l);
    foreach (stk[k]) if (stk[k] == l) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int best_pend();
    for (int l = 0; l < 8; l++)
      if (m_req[l] && m_en[l] && !in_svc(l)) return l;
    return -1;
  endfunction

  function automatic bit m_int();
    int b = best_pend();
    if (b < 0) return 1'b0;
    return (stk.size() == 0) || (b < stk[0]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_req[l]) begin m_req[l] = 0; m_en[l] = 0; end
      m_base = 0; stk.delete(); m_vld = 0; m_vec = 0;
    end else begin
      bit take;
      int b;
      take = ack && m_int();
      b = best_pend();
      if (we && addr == 2'd2 && stk.size() > 0) void'(stk.pop_front());
      if (take) begin
        stk.push_front(b);
        m_vec = m_base * 8 + b;
      end
      m_vld = take;
      if (we && addr == 2'd0) foreach (m_en[l]) m_en[l] = wdata[l];
      if (we && addr == 2'd1) m_base = wdata[4:0];
      foreach (m_req[l]) m_req[l] = irq[l];
    end
    #1;
    chk({cur, " int_o"}, int_w, m_int());
    chk({cur, " vec_valid_o"}, vld_w, m_vld);
    chk({cur, " vec_o"}, vec_w, m_vec);
    chk("R6 tbl_addr_o", tbl_w, m_vec * 4);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; addr = a[1:0]; wdata = d[7:0];
    @(negedge clk); we = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk("R10 reset int_o", int_w, 0);
    chk("R10 reset vec_o", vec_w, 0);
    // R2: nothing enabled after reset
    cur = "R2"; irq = 8'hFF; cyc(3);
    chk("R2 masked int_o", int_w, 0);
    cur = "R5"; pulse_ack(); cyc(1);
    chk("R5 stray ack vec_valid_o", vld_w, 0);
    irq = 0;
    wr(0, 8'hFF); wr(1, 8'h11);
    // R1 / R4 / R6: single line 5
    cur = "R1"; @(negedge clk); irq = 8'h20; cyc(1);
    chk("R1 one-cycle latency", int_w, 1);
    cur = "R4"; ack = 1; cyc(1); ack = 0;
    chk("R4 vec_valid_o", vld_w, 1);
    chk("R6 vector", vec_w, 8'h8D);
    chk("R6 table address", tbl_w, 10'h234);
    chk("R8 same line still requesting", int_w, 0);
    irq = 0; wr(2, 0); cyc(2);
    // Nesting: line 6 low, line 1 pre-empts, line 3 waits
    cur = "R7"; irq = 8'h40; cyc(1); pulse_ack();
    irq = 8'h42; cyc(1);
    chk("R7 pre-empt", int_w, 1);
    pulse_ack(); cyc(1);
    chk("R7 nested vector", vec_w, 8'h89);
    cur = "R8"; irq = 8'h4A; cyc(2);
    chk("R8 lower deferred", int_w, 0);
    cur = "R9"; irq = 8'h48; wr(2, 8'h55);
    chk("R9 waiting line signalled", int_w, 1);
    pulse_ack(); cyc(1);
    chk("R9 served middle line", vec_w, 8'h8B);
    irq = 8'h40; wr(2, 0); cyc(1);
    chk("R9 resumed low level, no new int", int_w, 0);
    irq = 0; wr(2, 0); cyc(2);
    // R3: simultaneous lines 4 and 2
    cur = "R3"; irq = 8'h14; cyc(2); pulse_ack(); cyc(1);
    chk("R3 higher priority chosen", vec_w, 8'h8A);
    irq = 0; wr(2, 0); cyc(2);
    // R11: address 3 write ignored
    cur = "R11"; wr(3, 8'h00); irq = 8'h01; cyc(2);
    chk("R11 enables unchanged", int_w, 1);
    pulse_ack(); irq = 0; wr(2, 0);
    // R2: disable line 0 only
    cur = "R2"; wr(0, 8'hFE); irq = 8'h01; cyc(3);
    chk("R2 disabled line", int_w, 0);
    // Random mix
    cur = "R9 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      irq = $urandom();
      ack = (r < 30);
      we = 0;
      if (r >= 30 && r < 45)      begin we = 1; addr = 2'd2; wdata = $urandom(); end
      else if (r >= 45 && r < 49) begin we = 1; addr = 2'd0; wdata = $urandom(); end
      else if (r >= 49 && r < 51) begin we = 1; addr = 2'd1; wdata = $urandom(); end
      else if (r >= 51 && r < 53) begin we = 1; addr = 2'd3; wdata = $urandom(); end
    end
    @(negedge clk); ack = 0; we = 0; irq = 0;
    cyc(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule